// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Three Interrupt Routes

This block is one general-purpose I/O port of eight pins. A byte-wide register bank, reached over a simple byte-addressed write/read bus, holds the per-pin settings: input enable, output enable (active low), output value, event polarity, drive strength, I/O-function select, and one interrupt enable byte for each of three interrupt routes. The pad side sees the output value, the active-low output enable, the drive-strength and function-select bits, and delivers the raw pad levels, which pass through a two-flop synchronizer.

Each synchronized pin is adjusted by its polarity bit and then offered to three independent interrupt routes. A route looks only at the pins enabled in its own enable byte. It works either on edges, where its pending flag is sticky until software clears it, or on levels, where the flag tracks the OR of its active enabled pins. A route drives its interrupt line only while its mask bit is set. Route 0 also needs a core enable bit. Software clears pending flags by writing ones to the status offset.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, except drive strength (offset 5), which reads 0xFF. All three interrupt lines are low.
- R2: The offsets are: 0 input (read only; writes are ignored), 1 input enable, 2 output enable active low, 3 output value, 4 polarity, 5 drive strength, 6 function select, 7/8/9 enable bytes of routes 0/1/2, 10 control, 11 status. Bit i of every per-pin byte belongs to pin i. Writable registers read back what was written.
- R3: Offset 0 reads the pad value as it stood two clock edges earlier, ANDed with the input enable byte. Pins with input enable 0 read 0.
- R4: pad_out, pad_oe_n, pad_drv and pad_func equal the output value, output-enable (0 drives the pad), drive-strength and function-select registers.
- R5: A polarity bit of 0 makes its pin active on a rising edge or a high level. A polarity bit of 1 makes it active on a falling edge or a low level.
- R6: In edge mode, a route's status bit (bit r at offset 11) becomes 1 on the third clock edge after an enabled pin makes its active transition, and it stays 1. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the flag stays set.
- R7: In level mode, a route's status bit equals, one edge after the synchronized value, the OR of its enabled, polarity-adjusted pins. A clear write does not drop it while such a pin is active.
- R8: A pin affects only the routes whose enable byte has its bit set.
- R9: Control byte: bits [2:0] set level mode for routes 0..2, bits [5:3] are the mask bits of routes 0..2, and bit 6 is the core enable. irq[r] = status[r] AND mask[r], and irq[0] additionally needs the core enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Output value to pads |
| pad_oe_n | output | 8 | Output enable, 0 drives the pad |
| pad_drv | output | 8 | Drive strength, 1 is maximum |
| pad_func | output | 8 | 1 selects the I/O function of the pin |
| irq | output | 3 | Interrupt lines of routes 0..2 |

## Verification
The routes are driven with random pad bytes, each held for four cycles, under random polarity, enable bytes, level/edge selects, masks and core enable. This separates edges from levels, inverted from plain polarity, and one route's enables from another's. Directed cases pin down the exact three-edge latency of an edge event, a clear arriving in the same cycle as a set, a clear against a still-active level, and gating by the mask and core enable. Further directed cases check that writes to the input offset are ignored and that input enable masks the read value.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int unsigned OFF_INPUT = 0;
    localparam int unsigned OFF_INEN  = 1;
    localparam int unsigned OFF_OEN_N = 2;
    localparam int unsigned OFF_OUTV  = 3;
    localparam int unsigned OFF_POL   = 4;
    localparam int unsigned OFF_DRV   = 5;
    localparam int unsigned OFF_FUNC  = 6;
    localparam int unsigned OFF_EN0   = 7;
    localparam int unsigned OFF_CTRL  = 10;
    localparam int unsigned OFF_STAT  = 11;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pad_i,
    output logic [PINS-1:0] sync_o,
    output logic [PINS-1:0] prev_o
);
    typedef struct packed {
        logic [PINS-1:0] s1;
        logic [PINS-1:0] s2;
        logic [PINS-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pad_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS   = 8,
    parameter int unsigned ROUTES = 3,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [PINS-1:0]              wdata_i,
    output logic [PINS-1:0]              rdata_o,
    input  logic [PINS-1:0]              sync_i,
    input  logic [ROUTES-1:0]            status_i,
    output logic [PINS-1:0]              in_en_o,
    output logic [PINS-1:0]              oen_n_o,
    output logic [PINS-1:0]              outv_o,
    output logic [PINS-1:0]              pol_o,
    output logic [PINS-1:0]              drv_o,
    output logic [PINS-1:0]              func_o,
    output logic [ROUTES-1:0][PINS-1:0]  ren_o,
    output logic [ROUTES-1:0]            level_o,
    output logic [ROUTES-1:0]            mask_o,
    output logic                         core_o,
    output logic [ROUTES-1:0]            clr_o
);
    localparam int unsigned CORE_BIT = 2 * ROUTES;

    typedef struct packed {
        logic [PINS-1:0]             in_en;
        logic [PINS-1:0]             oen_n;
        logic [PINS-1:0]             outv;
        logic [PINS-1:0]             pol;
        logic [PINS-1:0]             drv;
        logic [PINS-1:0]             func;
        logic [ROUTES-1:0][PINS-1:0] ren;
        logic [ROUTES-1:0]           level;
        logic [ROUTES-1:0]           mask;
        logic                        core;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        clr_o  = '0;
        if (we_i) begin
            case (addr_i)
                ADDR_W'(OFF_INEN):  bank_d.in_en = wdata_i;
                ADDR_W'(OFF_OEN_N): bank_d.oen_n = wdata_i;
                ADDR_W'(OFF_OUTV):  bank_d.outv  = wdata_i;
                ADDR_W'(OFF_POL):   bank_d.pol   = wdata_i;
                ADDR_W'(OFF_DRV):   bank_d.drv   = wdata_i;
                ADDR_W'(OFF_FUNC):  bank_d.func  = wdata_i;
                ADDR_W'(OFF_CTRL): begin
                    bank_d.level = wdata_i[ROUTES-1:0];
                    bank_d.mask  = wdata_i[2*ROUTES-1:ROUTES];
                    bank_d.core  = wdata_i[CORE_BIT];
                end
                ADDR_W'(OFF_STAT):  clr_o = wdata_i[ROUTES-1:0];
                default: ;
            endcase
            for (int r = 0; r < ROUTES; r++) begin
                if (addr_i == ADDR_W'(OFF_EN0 + r)) bank_d.ren[r] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q     <= '0;
            bank_q.drv <= '1;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(OFF_INPUT): rdata_o = sync_i & bank_q.in_en;
            ADDR_W'(OFF_INEN):  rdata_o = bank_q.in_en;
            ADDR_W'(OFF_OEN_N): rdata_o = bank_q.oen_n;
            ADDR_W'(OFF_OUTV):  rdata_o = bank_q.outv;
            ADDR_W'(OFF_POL):   rdata_o = bank_q.pol;
            ADDR_W'(OFF_DRV):   rdata_o = bank_q.drv;
            ADDR_W'(OFF_FUNC):  rdata_o = bank_q.func;
            ADDR_W'(OFF_CTRL): begin
                rdata_o[ROUTES-1:0]        = bank_q.level;
                rdata_o[2*ROUTES-1:ROUTES] = bank_q.mask;
                rdata_o[CORE_BIT]          = bank_q.core;
            end
            ADDR_W'(OFF_STAT):  rdata_o[ROUTES-1:0] = status_i;
            default: ;
        endcase
        for (int r = 0; r < ROUTES; r++) begin
            if (addr_i == ADDR_W'(OFF_EN0 + r)) rdata_o = bank_q.ren[r];
        end
    end

    assign in_en_o = bank_q.in_en;
    assign oen_n_o = bank_q.oen_n;
    assign outv_o  = bank_q.outv;
    assign pol_o   = bank_q.pol;
    assign drv_o   = bank_q.drv;
    assign func_o  = bank_q.func;
    assign ren_o   = bank_q.ren;
    assign level_o = bank_q.level;
    assign mask_o  = bank_q.mask;
    assign core_o  = bank_q.core;

    assert_outv_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_W'(OFF_OUTV)) |=> (outv_o == $past(wdata_i)));

    assert_input_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(OFF_INPUT)) |-> ((rdata_o & ~in_en_o) == '0));
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
    parameter int unsigned PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] en_i,
    input  logic [PINS-1:0] adj_i,
    input  logic [PINS-1:0] adj_prev_i,
    input  logic            level_i,
    input  logic            clr_i,
    input  logic            gate_i,
    output logic            status_o,
    output logic            irq_o
);
    typedef struct packed {
        logic status;
    } route_t;

    route_t rt_d, rt_q;
    logic   hit;
    logic   active;

    assign hit    = |(en_i & adj_i & ~adj_prev_i);
    assign active = |(en_i & adj_i);

    always_comb begin
        rt_d = rt_q;
        if (level_i) rt_d.status = active;
        else         rt_d.status = (rt_q.status & ~clr_i) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign status_o = rt_q.status;
    assign irq_o    = rt_q.status & gate_i;

    assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_i && status_o && !clr_i) |=> status_o);

    assert_edge_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_i && clr_i && !(|(en_i & adj_i & ~adj_prev_i))) |=> !status_o);

    assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level_i |=> (status_o == $past(|(en_i & adj_i))));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
    parameter int unsigned PINS   = 8,
    parameter int unsigned ROUTES = 3,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PINS-1:0]   reg_wdata,
    output logic [PINS-1:0]   reg_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe_n,
    output logic [PINS-1:0]   pad_drv,
    output logic [PINS-1:0]   pad_func,
    output logic [ROUTES-1:0] irq
);
    logic [PINS-1:0]             sync_v, prev_v, adj, adj_prev;
    logic [PINS-1:0]             in_en, pol;
    logic [ROUTES-1:0][PINS-1:0] ren;
    logic [ROUTES-1:0]           level, mask, clr, status, gate;
    logic                        core;

    gpio_irq_sync #(.PINS(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_in),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    gpio_irq_regs #(.PINS(PINS), .ROUTES(ROUTES), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .rdata_o  (reg_rdata),
        .sync_i   (sync_v),
        .status_i (status),
        .in_en_o  (in_en),
        .oen_n_o  (pad_oe_n),
        .outv_o   (pad_out),
        .pol_o    (pol),
        .drv_o    (pad_drv),
        .func_o   (pad_func),
        .ren_o    (ren),
        .level_o  (level),
        .mask_o   (mask),
        .core_o   (core),
        .clr_o    (clr)
    );

    assign adj      = sync_v ^ pol;
    assign adj_prev = prev_v ^ pol;

    for (genvar r = 0; r < ROUTES; r++) begin : g_route
        if (r == 0) begin : g_core
            assign gate[r] = mask[r] & core;
        end else begin : g_plain
            assign gate[r] = mask[r];
        end

        gpio_irq_route #(.PINS(PINS)) u_route (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (ren[r]),
            .adj_i      (adj),
            .adj_prev_i (adj_prev),
            .level_i    (level[r]),
            .clr_i      (clr[r]),
            .gate_i     (gate[r]),
            .status_o   (status[r]),
            .irq_o      (irq[r])
        );
    end

    assert_core_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> (core && mask[0]));

    assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~status) == '0));

    assert_route_isolation_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!level[1] && ren[1] == '0 && !status[1]) |=> !status[1]);
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe_n, pad_drv, pad_func;
    logic [2:0] irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] pol_m, pad_m;
    logic [7:0] en_m [3];
    logic [2:0] lvl_m, msk_m, exp_edge, exp_st;
    logic       core_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe_n(pad_oe_n), .pad_drv(pad_drv),
        .pad_func(pad_func), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_pad(input logic [7:0] v);
        pad_m = v;
        pad_in = v;
    endtask

    function automatic logic [2:0] exp_irq(input logic [2:0] st);
        return st & msk_m & {2'b11, core_m};
    endfunction

    function automatic logic edge_hit(input logic [7:0] en, input logic [7:0] pol,
                                      input logic [7:0] oldp, input logic [7:0] newp);
        return |(en & ~(oldp ^ pol) & (newp ^ pol));
    endfunction

    function automatic logic lvl_hit(input logic [7:0] en, input logic [7:0] pol,
                                     input logic [7:0] p);
        return |(en & (p ^ pol));
    endfunction

    task automatic write_cfg();
        wr(4'd4, pol_m);
        wr(4'd7, en_m[0]);
        wr(4'd8, en_m[1]);
        wr(4'd9, en_m[2]);
        wr(4'd10, {1'b0, core_m, msk_m, lvl_m});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] oldp;
        void'($urandom(32'd20240611));
        pad_m = '0;
        tick(3);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), v);
            chk("R1 reset value", {24'd0, v}, (a == 5) ? 32'hFF : 32'h0);
        end
        chk("R1 irq after reset", {29'd0, irq}, 32'h0);

        // R2: readback of writable registers, input offset ignores writes
        for (int a = 1; a < 11; a++) begin
            logic [7:0] d;
            d = (a == 10) ? 8'($urandom) & 8'h7F : 8'($urandom);
            wr(4'(a), d);
            rd(4'(a), v);
            chk("R2 readback", {24'd0, v}, {24'd0, d});
        end
        wr(4'd1, 8'h00);
        wr(4'd10, 8'h00);
        wr(4'd11, 8'h07);
        wr(4'd0, 8'h5A);
        rd(4'd0, v);
        chk("R2 input offset write ignored", {24'd0, v}, 32'h0);

        // R4: pad outputs mirror their registers
        wr(4'd2, 8'h3C); wr(4'd3, 8'hA7); wr(4'd5, 8'h0F); wr(4'd6, 8'hE1);
        chk("R4 pad_oe_n", {24'd0, pad_oe_n}, 32'h3C);
        chk("R4 pad_out", {24'd0, pad_out}, 32'hA7);
        chk("R4 pad_drv", {24'd0, pad_drv}, 32'h0F);
        chk("R4 pad_func", {24'd0, pad_func}, 32'hE1);

        // R3: two-edge latency and input-enable gating
        wr(4'd1, 8'hF0);
        set_pad(8'hA5);
        tick(1);
        rd(4'd0, v);
        chk("R3 one edge after pad change", {24'd0, v}, 32'h0);
        tick(1);
        rd(4'd0, v);
        chk("R3 two edges after pad change", {24'd0, v}, 32'hA0);
        set_pad(8'h00);
        tick(3);

        // R6/R5: edge route 0, pin 3 rising, exact latency
        pol_m = 8'h00; en_m[0] = 8'h08; en_m[1] = 8'h00; en_m[2] = 8'h00;
        lvl_m = 3'b000; msk_m = 3'b001; core_m = 1'b1;
        write_cfg();
        wr(4'd11, 8'h07);
        set_pad(8'h08);
        tick(2);
        rd(4'd11, v);
        chk("R6 no status two edges after rise", {24'd0, v}, 32'h0);
        tick(1);
        rd(4'd11, v);
        chk("R6 status three edges after rise", {24'd0, v}, 32'h1);
        chk("R9 irq0 with mask and core", {29'd0, irq}, 32'h1);
        set_pad(8'h00);
        tick(4);
        rd(4'd11, v);
        chk("R6 sticky through falling edge", {24'd0, v}, 32'h1);
        wr(4'd11, 8'h00);
        rd(4'd11, v);
        chk("R6 writing 0 keeps status", {24'd0, v}, 32'h1);
        wr(4'd11, 8'h01);
        rd(4'd11, v);
        chk("R6 writing 1 clears status", {24'd0, v}, 32'h0);
        chk("R5 falling edge does not trigger with polarity 0", {29'd0, irq}, 32'h0);

        // R5: polarity 1 triggers on falling
        wr(4'd4, 8'h08);
        set_pad(8'h08);
        tick(4);
        rd(4'd11, v);
        chk("R5 rising ignored with polarity 1", {24'd0, v}, 32'h0);
        set_pad(8'h00);
        tick(4);
        rd(4'd11, v);
        chk("R5 falling triggers with polarity 1", {24'd0, v}, 32'h1);
        wr(4'd11, 8'h01);

        // R6: set and clear in the same cycle, set wins
        wr(4'd4, 8'h00);
        set_pad(8'h08);
        tick(2);
        wr(4'd11, 8'h01);
        rd(4'd11, v);
        chk("R6 set wins over simultaneous clear", {24'd0, v}, 32'h1);

        // R9: core enable and mask gating
        wr(4'd10, 8'h08);
        chk("R9 irq0 low without core enable", {29'd0, irq}, 32'h0);
        wr(4'd10, 8'h40);
        chk("R9 irq0 low without mask", {29'd0, irq}, 32'h0);
        wr(4'd11, 8'h07);
        set_pad(8'h00);
        tick(4);

        // R7/R8: level route 1, pin 2 high, route 0 not enabled on pin 2
        pol_m = 8'h00; en_m[0] = 8'h08; en_m[1] = 8'h04; en_m[2] = 8'h00;
        lvl_m = 3'b010; msk_m = 3'b010; core_m = 1'b0;
        write_cfg();
        set_pad(8'h04);
        tick(4);
        rd(4'd11, v);
        chk("R7 level status follows active pin; R8 route 0 untouched", {24'd0, v}, 32'h2);
        chk("R9 irq1 asserted without core enable", {29'd0, irq}, 32'h2);
        wr(4'd11, 8'h02);
        rd(4'd11, v);
        chk("R7 clear does not drop active level", {24'd0, v}, 32'h2);
        set_pad(8'h00);
        tick(4);
        rd(4'd11, v);
        chk("R7 level status drops with pin", {24'd0, v}, 32'h0);

        // Random blocks: R5 R6 R7 R8 R9
        for (int b = 0; b < 4; b++) begin
            pol_m = 8'($urandom);
            for (int r = 0; r < 3; r++) en_m[r] = 8'($urandom);
            lvl_m = 3'($urandom); msk_m = 3'($urandom); core_m = 1'($urandom);
            write_cfg();
            tick(4);
            wr(4'd11, 8'h07);
            exp_edge = '0;
            for (int i = 0; i < 12; i++) begin
                oldp = pad_m;
                set_pad(8'($urandom));
                tick(4);
                for (int r = 0; r < 3; r++) begin
                    exp_edge[r] = exp_edge[r] | edge_hit(en_m[r], pol_m, oldp, pad_m);
                    exp_st[r] = lvl_m[r] ? lvl_hit(en_m[r], pol_m, pad_m) : exp_edge[r];
                end
                rd(4'd11, v);
                chk("R6/R7/R8 random status", {24'd0, v}, {29'd0, exp_st});
                chk("R9 random irq", {29'd0, irq}, {29'd0, exp_irq(exp_st)});
                wr(4'd11, 8'h07);
                exp_edge = '0;
                for (int r = 0; r < 3; r++)
                    exp_st[r] = lvl_m[r] ? lvl_hit(en_m[r], pol_m, pad_m) : 1'b0;
                rd(4'd11, v);
                chk("R6/R7 random status after clear", {24'd0, v}, {29'd0, exp_st});
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule